// File: doc/BRIEF.md
# Local Bus Bank Decoder and Access Sequencer

This block selects one of eight external memory banks for each access on a local bus and then plays out the access timing toward the bus. Every bank owns a base word and an option word, both loaded over a small register port. An incoming request carries a 17-bit compare address and two extended address bits. Each bank compares these against its base under its own per-bit mask. The lowest-numbered matching bank is selected, and an address that no bank claims is refused with an error pulse.

Once a bank is chosen, the sequencer does the following:
- raises that bank's chip select;
- holds the address-latch strobe for one cycle or for a globally programmed count;
- drives the buffer-control line unless the bank disables it;
- runs data beats that the bus acknowledges one per cycle.

A burst to a bank that cannot burst becomes a train of single accesses, each with its own latch phase. After a read, a per-bank code holds off the next request for 0, 1, 4 or 8 idle cycles.

Top module: `lbb_bank_seq`

## Requirements
- R1: A valid bank (base word bit 0 = 1) matches when every request address bit whose mask bit is 1 equals the base bit (base word [31:15], mask in option word [31:15]). Address bits under a 0 mask bit are ignored. A bank with valid = 0 never matches.
- R2: Mask bits may form any pattern, so one bank can answer at several separate addresses.
- R3: The two extended request bits are compared with the base word [14:13] under the extended mask in option word [14:13].
- R4: At most one chip-select bit is ever high, and when several banks match, the lowest-numbered bank is selected.
- R5: A request that matches no bank produces a one-cycle resp_err in the cycle after acceptance. It raises no chip select, no address latch and no buffer control.
- R6: With option bit 0 = 0, addr_latch is high for exactly one cycle per access. With bit 0 = 1, it is high for the number of cycles set by the global word (offset 0x40, bits [1:0]): 1→2, 2→3, 3→4, 0→4.
- R7: buf_ctl is high in every cycle the chip select is high when option bit 4 = 0, and it stays low for the whole access when bit 4 = 1.
- R8: A burst request (4 beats) is one latch phase followed by 4 data beats with burst_out high when option bit 3 = 0. When bit 3 = 1, it is 4 single accesses, each with its own latch phase, and burst_out stays low. A non-burst request is one beat.
- R9: After the final beat of a read, req_ready stays low for 0, 1, 4 or 8 cycles for option bits [2:1] = 00, 01, 10, 11. After a write, there is no idle gap.
- R10: The base word of bank n sits at offset 8n and the option word at 8n+4. reg_rdata presents the addressed word one cycle after reg_rd. Unused bits read 0 and ignore writes, and all words reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_addr | input | 17 | Compare address |
| req_xaddr | input | 2 | Extended address bits |
| req_read | input | 1 | 1 = read, 0 = write |
| req_burst | input | 1 | 1 = four-beat burst |
| bus_ack | input | 1 | Bus acknowledges the current data beat |
| bank_cs | output | 8 | One-hot chip selects |
| addr_latch | output | 1 | Address-latch strobe |
| buf_ctl | output | 1 | Data buffer control |
| data_phase | output | 1 | A data beat is in progress |
| burst_out | output | 1 | Current beat belongs to a burst |
| resp_done | output | 1 | Final beat acknowledged |
| resp_err | output | 1 | Request matched no bank |

## Verification
The properties assume that request fields hold steady while req_valid is high. They also assume that bus_ack matters only while data_phase is high, and that bank words change only while the sequencer is idle. The bench meets these conditions in three ways. It drives each request for exactly one accepted cycle. It keeps bus_ack high throughout. It writes registers only between accesses, after req_ready has returned.

// File: rtl/lbb_pkg.sv
package lbb_pkg;

    localparam int LBB_AW = 17;
    localparam int LBB_XW = 2;
    localparam int LBB_DW = 32;

    typedef struct packed {
        logic [LBB_AW-1:0] base;
        logic [LBB_XW-1:0] xbase;
        logic              valid;
    } base_cfg_t;

    typedef struct packed {
        logic [LBB_AW-1:0] mask;
        logic [LBB_XW-1:0] xmask;
        logic              bctl_off;
        logic              no_burst;
        logic [1:0]        turn;
        logic              ext_ale;
    } opt_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ERR   = 3'd1,
        ST_LATCH = 3'd2,
        ST_DATA  = 3'd3,
        ST_TURN  = 3'd4
    } seq_state_t;

    function automatic logic [LBB_DW-1:0] base_pack(base_cfg_t c);
        return {c.base, c.xbase, {(LBB_DW-LBB_AW-LBB_XW-1){1'b0}}, c.valid};
    endfunction

    function automatic base_cfg_t base_unpack(logic [LBB_DW-1:0] w);
        base_cfg_t c;
        c.base  = w[LBB_DW-1 -: LBB_AW];
        c.xbase = w[LBB_DW-LBB_AW-1 -: LBB_XW];
        c.valid = w[0];
        return c;
    endfunction

    function automatic logic [LBB_DW-1:0] opt_pack(opt_cfg_t c);
        return {c.mask, c.xmask, {(LBB_DW-LBB_AW-LBB_XW-5){1'b0}},
                c.bctl_off, c.no_burst, c.turn, c.ext_ale};
    endfunction

    function automatic opt_cfg_t opt_unpack(logic [LBB_DW-1:0] w);
        opt_cfg_t c;
        c.mask     = w[LBB_DW-1 -: LBB_AW];
        c.xmask    = w[LBB_DW-LBB_AW-1 -: LBB_XW];
        c.bctl_off = w[4];
        c.no_burst = w[3];
        c.turn     = w[2:1];
        c.ext_ale  = w[0];
        return c;
    endfunction

    // Strobe length: one cycle, or the global code (1->2, 2->3, else 4).
    function automatic logic [2:0] latch_cycles(logic ext, logic [1:0] code);
        if (!ext) return 3'd1;
        case (code)
            2'd1:    return 3'd2;
            2'd2:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    // Read recovery gap, deliberately non-linear.
    function automatic logic [3:0] turn_cycles(logic [1:0] code);
        case (code)
            2'd0:    return 4'd0;
            2'd1:    return 4'd1;
            2'd2:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/lbb_regfile.sv
module lbb_regfile
    import lbb_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int RAW       = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [LBB_DW-1:0] reg_wdata,
    output logic [LBB_DW-1:0] reg_rdata,
    output base_cfg_t         base_cfg [NUM_BANKS],
    output opt_cfg_t          opt_cfg  [NUM_BANKS],
    output logic [1:0]        lat_code
);
    localparam int             IDX_W     = RAW - 3;
    localparam logic [RAW-1:0] GCTL_ADDR = RAW'(NUM_BANKS * 8);

    logic [IDX_W-1:0] idx;
    logic             word_ok;
    logic [LBB_DW-1:0] rd_word;

    assign idx     = reg_addr[RAW-1:3];
    assign word_ok = (reg_addr[1:0] == 2'b00);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        base_cfg_t base_r;
        opt_cfg_t  opt_r;
        logic      hit_w;

        assign hit_w = reg_wr && word_ok && (idx == IDX_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_r <= '0;
                opt_r  <= '0;
            end else if (hit_w) begin
                if (reg_addr[2]) opt_r  <= opt_unpack(reg_wdata);
                else             base_r <= base_unpack(reg_wdata);
            end
        end

        assign base_cfg[b] = base_r;
        assign opt_cfg[b]  = opt_r;
    end

    always_ff @(posedge clk) begin
        if (rst)                                lat_code <= 2'b00;
        else if (reg_wr && reg_addr == GCTL_ADDR) lat_code <= reg_wdata[1:0];
    end

    always_comb begin
        rd_word = '0;
        if (reg_addr == GCTL_ADDR) begin
            rd_word = {{(LBB_DW-2){1'b0}}, lat_code};
        end else if (word_ok) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (idx == IDX_W'(b))
                    rd_word = reg_addr[2] ? opt_pack(opt_cfg[b]) : base_pack(base_cfg[b]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

endmodule

// File: rtl/lbb_bank_match.sv
module lbb_bank_match
    import lbb_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  base_cfg_t                      base_cfg [NUM_BANKS],
    input  opt_cfg_t                       opt_cfg  [NUM_BANKS],
    input  logic [LBB_AW-1:0]              addr,
    input  logic [LBB_XW-1:0]              xaddr,
    output logic                           hit,
    output logic [$clog2(NUM_BANKS)-1:0]   hit_idx,
    output opt_cfg_t                       hit_opt
);
    localparam int BIDX_W = $clog2(NUM_BANKS);

    logic [NUM_BANKS-1:0] eq;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
        logic main_ok, ext_ok;
        assign main_ok = (((addr  ^ base_cfg[b].base)  & opt_cfg[b].mask)  == '0);
        assign ext_ok  = (((xaddr ^ base_cfg[b].xbase) & opt_cfg[b].xmask) == '0);
        assign eq[b]   = base_cfg[b].valid && main_ok && ext_ok;
    end

    // Scan from the top so the lowest matching bank is the last to write.
    always_comb begin
        hit_idx = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (eq[b]) hit_idx = BIDX_W'(b);
        end
    end

    assign hit     = |eq;
    assign hit_opt = opt_cfg[hit_idx];

endmodule

// File: rtl/lbb_access_fsm.sv
module lbb_access_fsm
    import lbb_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int BURST_BEATS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_read,
    input  logic                          req_burst,
    input  logic                          hit,
    input  logic [$clog2(NUM_BANKS)-1:0]  hit_idx,
    input  opt_cfg_t                      hit_opt,
    input  logic [1:0]                    lat_code,
    input  logic                          bus_ack,
    output logic                          req_ready,
    output logic [NUM_BANKS-1:0]          bank_cs,
    output logic                          addr_latch,
    output logic                          buf_ctl,
    output logic                          data_phase,
    output logic                          burst_out,
    output logic                          resp_done,
    output logic                          resp_err
);
    localparam int BIDX_W = $clog2(NUM_BANKS);
    localparam int BEAT_W = $clog2(BURST_BEATS) + 1;

    seq_state_t         state_q;
    logic [BIDX_W-1:0]  bank_q;
    opt_cfg_t           opt_q;
    logic               rd_q;
    logic               bmode_q;
    logic [BEAT_W-1:0]  beats_q;
    logic [2:0]         lat_q;
    logic [3:0]         turn_q;
    logic               active;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bank_q  <= '0;
            opt_q   <= '0;
            rd_q    <= 1'b0;
            bmode_q <= 1'b0;
            beats_q <= '0;
            lat_q   <= '0;
            turn_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (hit) begin
                            state_q <= ST_LATCH;
                            bank_q  <= hit_idx;
                            opt_q   <= hit_opt;
                            rd_q    <= req_read;
                            bmode_q <= req_burst && !hit_opt.no_burst;
                            beats_q <= req_burst ? BEAT_W'(BURST_BEATS - 1) : '0;
                            lat_q   <= latch_cycles(hit_opt.ext_ale, lat_code) - 3'd1;
                        end else begin
                            state_q <= ST_ERR;
                        end
                    end
                end
                ST_ERR: state_q <= ST_IDLE;
                ST_LATCH: begin
                    if (lat_q == '0) state_q <= ST_DATA;
                    else             lat_q   <= lat_q - 3'd1;
                end
                ST_DATA: begin
                    if (bus_ack) begin
                        if (beats_q == '0) begin
                            if (rd_q && opt_q.turn != 2'b00) begin
                                state_q <= ST_TURN;
                                turn_q  <= turn_cycles(opt_q.turn) - 4'd1;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            beats_q <= beats_q - 1'b1;
                            if (!bmode_q) begin
                                state_q <= ST_LATCH;
                                lat_q   <= latch_cycles(opt_q.ext_ale, lat_code) - 3'd1;
                            end
                        end
                    end
                end
                ST_TURN: begin
                    if (turn_q == '0) state_q <= ST_IDLE;
                    else              turn_q  <= turn_q - 4'd1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign active     = (state_q == ST_LATCH) || (state_q == ST_DATA);
    assign req_ready  = (state_q == ST_IDLE);
    assign bank_cs    = active ? (NUM_BANKS'(1) << bank_q) : '0;
    assign addr_latch = (state_q == ST_LATCH);
    assign buf_ctl    = active && !opt_q.bctl_off;
    assign data_phase = (state_q == ST_DATA);
    assign burst_out  = data_phase && bmode_q;
    assign resp_done  = data_phase && bus_ack && (beats_q == '0);
    assign resp_err   = (state_q == ST_ERR);

endmodule

// File: rtl/lbb_bank_seq.sv
module lbb_bank_seq
    import lbb_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int BURST_BEATS = 4,
    parameter int RAW         = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [RAW-1:0]         reg_addr,
    input  logic [LBB_DW-1:0]      reg_wdata,
    output logic [LBB_DW-1:0]      reg_rdata,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [LBB_AW-1:0]      req_addr,
    input  logic [LBB_XW-1:0]      req_xaddr,
    input  logic                   req_read,
    input  logic                   req_burst,
    input  logic                   bus_ack,
    output logic [NUM_BANKS-1:0]   bank_cs,
    output logic                   addr_latch,
    output logic                   buf_ctl,
    output logic                   data_phase,
    output logic                   burst_out,
    output logic                   resp_done,
    output logic                   resp_err
);
    localparam int BIDX_W = $clog2(NUM_BANKS);

    base_cfg_t         base_cfg [NUM_BANKS];
    opt_cfg_t          opt_cfg  [NUM_BANKS];
    logic [1:0]        lat_code;
    logic              hit;
    logic [BIDX_W-1:0] hit_idx;
    opt_cfg_t          hit_opt;

    lbb_regfile #(.NUM_BANKS(NUM_BANKS), .RAW(RAW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .base_cfg  (base_cfg),
        .opt_cfg   (opt_cfg),
        .lat_code  (lat_code)
    );

    lbb_bank_match #(.NUM_BANKS(NUM_BANKS)) u_match (
        .base_cfg (base_cfg),
        .opt_cfg  (opt_cfg),
        .addr     (req_addr),
        .xaddr    (req_xaddr),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .hit_opt  (hit_opt)
    );

    lbb_access_fsm #(.NUM_BANKS(NUM_BANKS), .BURST_BEATS(BURST_BEATS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_read   (req_read),
        .req_burst  (req_burst),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .hit_opt    (hit_opt),
        .lat_code   (lat_code),
        .bus_ack    (bus_ack),
        .req_ready  (req_ready),
        .bank_cs    (bank_cs),
        .addr_latch (addr_latch),
        .buf_ctl    (buf_ctl),
        .data_phase (data_phase),
        .burst_out  (burst_out),
        .resp_done  (resp_done),
        .resp_err   (resp_err)
    );

endmodule

// File: rtl/lbb_bank_seq_chk.sv
module lbb_bank_seq_chk #(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 hit,
    input logic [NUM_BANKS-1:0] bank_cs,
    input logic                 addr_latch,
    input logic                 buf_ctl,
    input logic                 data_phase,
    input logic                 burst_out,
    input logic                 resp_done,
    input logic                 resp_err
);
    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_cs));

    assert_miss_err_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !hit) |=> (resp_err && bank_cs == '0));

    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> (!addr_latch && !buf_ctl && bank_cs == '0));

    assert_latch_has_cs_R6: assert property (@(posedge clk) disable iff (rst)
        addr_latch |-> (bank_cs != '0 && !data_phase));

    assert_bctl_in_access_R7: assert property (@(posedge clk) disable iff (rst)
        buf_ctl |-> (bank_cs != '0));

    assert_burst_in_data_R8: assert property (@(posedge clk) disable iff (rst)
        burst_out |-> (data_phase && !addr_latch));

    assert_cs_held_R8: assert property (@(posedge clk) disable iff (rst)
        (bank_cs != '0 && !resp_done) |=> (bank_cs == $past(bank_cs)));

endmodule

bind lbb_bank_seq lbb_bank_seq_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .hit        (hit),
    .bank_cs    (bank_cs),
    .addr_latch (addr_latch),
    .buf_ctl    (buf_ctl),
    .data_phase (data_phase),
    .burst_out  (burst_out),
    .resp_done  (resp_done),
    .resp_err   (resp_err)
);

// File: tb/lbb_bank_seq_tb.sv
module lbb_bank_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [16:0] req_addr = '0;
    logic [1:0]  req_xaddr = '0;
    logic        req_read = 1'b0, req_burst = 1'b0;
    logic        bus_ack = 1'b1;
    logic [7:0]  bank_cs;
    logic        addr_latch, buf_ctl, data_phase, burst_out, resp_done, resp_err;

    int n_checks = 0, n_fail = 0;
    bit mon_on = 0;
    int m_lat, m_data, m_bst, m_buf, m_cs, m_rise, m_err;
    logic [7:0] m_cs_or;
    logic prev_lat;
    int gap;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbb_bank_seq u_dut (.*);

    always @(negedge clk) begin
        if (mon_on) begin
            if (addr_latch) m_lat++;
            if (data_phase) m_data++;
            if (burst_out)  m_bst++;
            if (buf_ctl)    m_buf++;
            if (|bank_cs) begin m_cs++; m_cs_or = m_cs_or | bank_cs; end
            if (addr_latch && !prev_lat) m_rise++;
            if (resp_err)   m_err++;
            prev_lat = addr_latch;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(logic [6:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rreg(logic [6:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic wbase(int n, logic [16:0] b, logic [1:0] xb, logic v);
        wreg(7'(8*n), {b, xb, 12'b0, v});
    endtask

    task automatic wopt(int n, logic [16:0] m, logic [1:0] xm, logic boff,
                        logic nob, logic [1:0] turn, logic ext);
        wreg(7'(8*n+4), {m, xm, 8'b0, boff, nob, turn, ext});
    endtask

    task automatic access(logic [16:0] a, logic [1:0] x, logic rd, logic bst);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        m_lat = 0; m_data = 0; m_bst = 0; m_buf = 0; m_cs = 0; m_rise = 0;
        m_err = 0; m_cs_or = '0; prev_lat = 0;
        mon_on = 1;
        req_valid = 1; req_addr = a; req_xaddr = x; req_read = rd; req_burst = bst;
        @(negedge clk);
        req_valid = 0;
        while (!(resp_done || resp_err)) @(negedge clk);
        gap = 0;
        @(negedge clk);
        while (!req_ready) begin gap++; @(negedge clk); end
        mon_on = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R10 ready after reset", int'(req_ready), 1);
        check("R10 cs after reset", int'(bank_cs), 0);
        rreg(7'h04, d); check("R10 opt0 reset", d, 0);
        rreg(7'h38, d); check("R10 base7 reset", d, 0);
        rreg(7'h40, d); check("R10 global reset", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wreg(7'h00, 32'hFFFF_FFFF); rreg(7'h00, d); check("R10 base reserved", d, 32'hFFFF_E001);
        wreg(7'h04, 32'hFFFF_FFFF); rreg(7'h04, d); check("R10 opt reserved", d, 32'hFFFF_E01F);
        wreg(7'h40, 32'hFFFF_FFFF); rreg(7'h40, d); check("R10 global reserved", d, 3);
        wreg(7'h1C, 32'h1234_6003); rreg(7'h1C, d); check("R10 opt3 offset", d, 32'h1234_6003);
        wreg(7'h00, 0); wreg(7'h04, 0); wreg(7'h40, 0); wreg(7'h1C, 0);
        rreg(7'h00, d); check("R10 base0 cleared", d, 0);
    endtask

    task automatic t_mask();
        wbase(2, 17'h00A00, 2'b00, 1); wopt(2, 17'h1FF00, 2'b00, 0, 0, 2'b00, 0);
        access(17'h00A55, 0, 0, 0);
        check("R1 masked low bits ignored", m_cs_or, 8'h04);
        access(17'h00B00, 0, 0, 0);
        check("R1 compared bit differs", m_err, 1);
        wbase(3, 17'h01000, 2'b00, 0); wopt(3, 17'h1FFFF, 2'b00, 0, 0, 2'b00, 0);
        access(17'h01000, 0, 0, 0);
        check("R1 invalid bank ignored", m_err, 1);
    endtask

    task automatic t_scatter();
        wbase(5, 17'h10001, 2'b00, 1); wopt(5, 17'h10001, 2'b00, 0, 0, 2'b00, 0);
        access(17'h10001, 0, 0, 0); check("R2 alias A", m_cs_or, 8'h20);
        access(17'h1FFFF, 0, 0, 0); check("R2 alias B", m_cs_or, 8'h20);
        access(17'h00001, 0, 0, 0); check("R2 sparse bit mismatch", m_err, 1);
    endtask

    task automatic t_xaddr();
        wbase(6, 17'h04000, 2'b10, 1); wopt(6, 17'h1FFFF, 2'b11, 0, 0, 2'b00, 0);
        access(17'h04000, 2'b10, 0, 0); check("R3 ext bits match", m_cs_or, 8'h40);
        access(17'h04000, 2'b01, 0, 0); check("R3 ext bits mismatch", m_err, 1);
        wopt(6, 17'h1FFFF, 2'b10, 0, 0, 2'b00, 0);
        access(17'h04000, 2'b11, 0, 0); check("R3 ext bit masked", m_cs_or, 8'h40);
    endtask

    task automatic t_priority();
        wbase(1, 17'h08000, 2'b00, 1); wopt(1, 17'h1F000, 2'b00, 0, 0, 2'b00, 0);
        wbase(4, 17'h08000, 2'b00, 1); wopt(4, 17'h1FFFF, 2'b00, 0, 0, 2'b00, 0);
        access(17'h08000, 0, 0, 0); check("R4 lowest bank wins", m_cs_or, 8'h02);
        access(17'h08123, 0, 0, 0); check("R4 only wider bank", m_cs_or, 8'h02);
        wbase(1, 17'h08000, 2'b00, 0);
        access(17'h08000, 0, 0, 0); check("R4 next bank after invalidate", m_cs_or, 8'h10);
    endtask

    task automatic t_miss();
        access(17'h1F0F0, 0, 1, 1);
        check("R5 error pulse", m_err, 1);
        check("R5 no cs", m_cs, 0);
        check("R5 no latch", m_lat, 0);
        check("R5 no buf", m_buf, 0);
        check("R5 no gap", gap, 0);
    endtask

    task automatic t_latch();
        wbase(7, 17'h1E000, 2'b00, 1);
        wopt(7, 17'h1FFFF, 2'b00, 0, 0, 2'b00, 0);
        access(17'h1E000, 0, 0, 0); check("R6 single strobe", m_lat, 1);
        wopt(7, 17'h1FFFF, 2'b00, 0, 0, 2'b00, 1);
        for (int c = 0; c < 4; c++) begin
            wreg(7'h40, 32'(c));
            access(17'h1E000, 0, 0, 0);
            check($sformatf("R6 extended strobe code %0d", c), m_lat, (c == 1) ? 2 : (c == 2) ? 3 : 4);
        end
        wreg(7'h40, 0);
    endtask

    task automatic t_bctl();
        wopt(7, 17'h1FFFF, 2'b00, 0, 0, 2'b00, 0);
        access(17'h1E000, 0, 0, 0);
        check("R7 buf with cs", m_buf, m_cs);
        check("R7 cs cycles", m_cs, 2);
        wopt(7, 17'h1FFFF, 2'b00, 1, 0, 2'b00, 0);
        access(17'h1E000, 0, 0, 0);
        check("R7 buf disabled", m_buf, 0);
        check("R7 cs still driven", m_cs_or, 8'h80);
    endtask

    task automatic t_burst();
        wopt(7, 17'h1FFFF, 2'b00, 0, 0, 2'b00, 0);
        access(17'h1E000, 0, 1, 1);
        check("R8 burst latch", m_lat, 1);
        check("R8 burst beats", m_data, 4);
        check("R8 burst flag", m_bst, 4);
        wopt(7, 17'h1FFFF, 2'b00, 0, 1, 2'b00, 0);
        access(17'h1E000, 0, 1, 1);
        check("R8 split latch phases", m_rise, 4);
        check("R8 split beats", m_data, 4);
        check("R8 split no burst flag", m_bst, 0);
        access(17'h1E000, 0, 1, 0);
        check("R8 single beat", m_data, 1);
    endtask

    task automatic t_turn();
        for (int c = 0; c < 4; c++) begin
            wopt(7, 17'h1FFFF, 2'b00, 0, 0, 2'(c), 0);
            access(17'h1E000, 0, 1, 0);
            check($sformatf("R9 read gap code %0d", c), gap, (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 4 : 8);
        end
        access(17'h1E000, 0, 0, 0);
        check("R9 write no gap", gap, 0);
        access(17'h1E000, 0, 1, 1);
        check("R9 gap after burst read", gap, 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_mask();
        t_scatter();
        t_xaddr();
        t_priority();
        t_miss();
        t_latch();
        t_bctl();
        t_burst();
        t_turn();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule